// File: doc/BRIEF.md
# Sprite graphics vertical-delay registers

This block holds the bitmap bytes for two 8-bit player sprites and the one-bit ball enable of a video generator. Each of the three objects keeps a pending copy (the "new" register, loaded from the bus) and a delayed copy (the "old" register, filled only by the block itself). A per-object delay-select bit picks which copy drives that object's output. A kernel can therefore change several sprite patterns in the middle of a scan line and have them take effect together on the next line.

The write side is a plain CPU-style strobe with an address and a data byte. There is no back-pressure: every cycle in which `wr_en` is high is accepted. The write is captured into a one-entry write stage and applied one clock later.

A player-0 graphics write has a side effect: it moves player-1's pending byte into player-1's delayed register. A player-1 graphics write moves player-0's pending byte and the pending ball bit into their delayed registers. These moves happen whatever the delay-select bits are. Both new and old contents are exposed for debug.

Top module: `sprite_vdelay`

Address map:

| Address | Register written |
|---|---|
| 0 | player-0 graphics |
| 1 | player-1 graphics |
| 2 | ball enable |
| 3 | player-0 delay select |
| 4 | player-1 delay select |
| 5 | ball delay select |

## Requirements
- R1: A synchronous reset clears every new, old and delay-select register, and the write stage, so all outputs read zero.
- R2: Any write accepted at a rising edge (wr_en high) takes effect at the following rising edge. A write to address 0 loads wr_data into player-0 new.
- R3: An address-0 write also copies player-1 new, as it stood before that update, into player-1 old. Player-0 old and both ball registers are left unchanged.
- R4: An address-1 write loads wr_data into player-1 new. In the same update it copies player-0 new into player-0 old and ball new into ball old.
- R5: An address-2 write sets ball new to wr_data bit 1, and touches no other register.
- R6: Writes to addresses 3, 4 and 5 set the delay-select bit of player 0, player 1 and the ball from wr_data bit 0. Each output shows the old copy when its bit is 1 and the new copy when its bit is 0.
- R7: The new-to-old copies of R3 and R4 happen whatever the delay-select bits are.
- R8: Writes on consecutive cycles are each applied in order, one cycle later. A copy uses the new value that results from all earlier applied writes.
- R9: Writes to addresses 6 and 7 change nothing. Data bits other than the one named for addresses 2 to 5 have no effect.
- R10: The debug outputs show the new and old contents of all three objects and the three delay-select bits at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe, always accepted |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| p0_gfx | output | 8 | Selected player-0 pattern |
| p1_gfx | output | 8 | Selected player-1 pattern |
| ball_en | output | 1 | Selected ball enable |
| p0_new | output | 8 | Player-0 new register |
| p0_old | output | 8 | Player-0 old register |
| p1_new | output | 8 | Player-1 new register |
| p1_old | output | 8 | Player-1 old register |
| ball_new | output | 1 | Ball new bit |
| ball_old | output | 1 | Ball old bit |
| dly_sel | output | 3 | Delay selects: bit 0 player 0, bit 1 player 1, bit 2 ball |

## Verification
The hardest case is a copy that must see a pending value written one cycle earlier. Examples are an address-0 write directly followed by an address-1 write, or a ball write directly followed by a player-1 write. These only happen with back-to-back strobes. The stimulus runs long unbroken bursts of alternating and pseudo-random writes, with the delay selects set in every combination. A behavioural model replays the one-cycle queue and is compared with every output on every clock.

// File: rtl/svd_pkg.sv
package svd_pkg;
  localparam int ADDR_W = 3;
  localparam int GFX_W  = 8;
  localparam int N_OBJ  = 3;

  localparam logic [ADDR_W-1:0] ADR_GFX0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_GFX1 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BALL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DLY0 = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DLY1 = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_DLYB = 3'd5;

  localparam int BALL_BIT = 1;
  localparam int DLY_BIT  = 0;

  localparam int OBJ_P0 = 0;
  localparam int OBJ_P1 = 1;
  localparam int OBJ_BL = 2;
endpackage

// File: rtl/svd_wr_stage.sv
module svd_wr_stage #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          q_vld,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld  <= 1'b0;
      q_addr <= '0;
      q_data <= '0;
    end else begin
      q_vld  <= wr_en;
      q_addr <= wr_addr;
      q_data <= wr_data;
    end
  end

  a_r8_stage_take: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (q_vld && q_addr == $past(wr_addr) && q_data == $past(wr_data)));
  a_r8_stage_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !q_vld);
endmodule

// File: rtl/svd_decode.sv
module svd_decode #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int NO = 3
) (
  input  logic          q_vld,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_data,
  output logic [NO-1:0] ld_new,
  output logic [NO-1:0] cp_old,
  output logic [NO-1:0] ld_dly,
  output logic          ball_val,
  output logic          dly_val
);
  import svd_pkg::*;

  logic hit_g0, hit_g1, hit_bl;

  always_comb begin
    hit_g0 = q_vld && (q_addr == AW'(ADR_GFX0));
    hit_g1 = q_vld && (q_addr == AW'(ADR_GFX1));
    hit_bl = q_vld && (q_addr == AW'(ADR_BALL));
    ld_new = '0;
    cp_old = '0;
    ld_dly = '0;
    ld_new[OBJ_P0] = hit_g0;
    ld_new[OBJ_P1] = hit_g1;
    ld_new[OBJ_BL] = hit_bl;
    cp_old[OBJ_P1] = hit_g0;
    cp_old[OBJ_P0] = hit_g1;
    cp_old[OBJ_BL] = hit_g1;
    ld_dly[OBJ_P0] = q_vld && (q_addr == AW'(ADR_DLY0));
    ld_dly[OBJ_P1] = q_vld && (q_addr == AW'(ADR_DLY1));
    ld_dly[OBJ_BL] = q_vld && (q_addr == AW'(ADR_DLYB));
    ball_val = q_data[BALL_BIT];
    dly_val  = q_data[DLY_BIT];
  end
endmodule

// File: rtl/svd_obj_reg.sv
module svd_obj_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         cp,
  input  logic         dly_ld,
  input  logic         dly_val,
  output logic [W-1:0] new_q,
  output logic [W-1:0] old_q,
  output logic         dly_q,
  output logic [W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      new_q <= '0;
      old_q <= '0;
      dly_q <= 1'b0;
    end else begin
      if (ld)     new_q <= ld_val;
      if (cp)     old_q <= new_q;
      if (dly_ld) dly_q <= dly_val;
    end
  end

  always_comb sel_q = dly_q ? old_q : new_q;

  a_r2_load_new: assert property (@(posedge clk) disable iff (rst)
    ld |=> new_q == $past(ld_val));
  a_r3_copy_old: assert property (@(posedge clk) disable iff (rst)
    cp |=> old_q == $past(new_q));
  a_r9_new_hold: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(new_q));
  a_r9_old_hold: assert property (@(posedge clk) disable iff (rst)
    !cp |=> $stable(old_q));
  a_r6_dly_hold: assert property (@(posedge clk) disable iff (rst)
    !dly_ld |=> $stable(dly_q));
endmodule

// File: rtl/sprite_vdelay.sv
module sprite_vdelay #(
  parameter int ADDR_W = svd_pkg::ADDR_W,
  parameter int GFX_W  = svd_pkg::GFX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GFX_W-1:0]  wr_data,
  output logic [GFX_W-1:0]  p0_gfx,
  output logic [GFX_W-1:0]  p1_gfx,
  output logic              ball_en,
  output logic [GFX_W-1:0]  p0_new,
  output logic [GFX_W-1:0]  p0_old,
  output logic [GFX_W-1:0]  p1_new,
  output logic [GFX_W-1:0]  p1_old,
  output logic              ball_new,
  output logic              ball_old,
  output logic [2:0]        dly_sel
);
  import svd_pkg::*;
  localparam int NO = N_OBJ;
  localparam int NP = 2;

  logic              q_vld;
  logic [ADDR_W-1:0] q_addr;
  logic [GFX_W-1:0]  q_data;
  logic [NO-1:0]     ld_new, cp_old, ld_dly, dly_q;
  logic              ball_val, dly_val;
  logic [GFX_W-1:0]  pn [NP];
  logic [GFX_W-1:0]  po [NP];
  logic [GFX_W-1:0]  ps [NP];
  logic              bn, bo, bs;

  svd_wr_stage #(.AW(ADDR_W), .DW(GFX_W)) i_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_vld(q_vld), .q_addr(q_addr), .q_data(q_data)
  );

  svd_decode #(.AW(ADDR_W), .DW(GFX_W), .NO(NO)) i_dec (
    .q_vld(q_vld), .q_addr(q_addr), .q_data(q_data),
    .ld_new(ld_new), .cp_old(cp_old), .ld_dly(ld_dly),
    .ball_val(ball_val), .dly_val(dly_val)
  );

  for (genvar g = 0; g < NP; g++) begin : g_player
    svd_obj_reg #(.W(GFX_W)) i_obj (
      .clk(clk), .rst(rst), .ld(ld_new[g]), .ld_val(q_data), .cp(cp_old[g]),
      .dly_ld(ld_dly[g]), .dly_val(dly_val),
      .new_q(pn[g]), .old_q(po[g]), .dly_q(dly_q[g]), .sel_q(ps[g])
    );
  end

  svd_obj_reg #(.W(1)) i_ball (
    .clk(clk), .rst(rst), .ld(ld_new[OBJ_BL]), .ld_val(ball_val), .cp(cp_old[OBJ_BL]),
    .dly_ld(ld_dly[OBJ_BL]), .dly_val(dly_val),
    .new_q(bn), .old_q(bo), .dly_q(dly_q[OBJ_BL]), .sel_q(bs)
  );

  always_comb begin
    p0_gfx   = ps[OBJ_P0];
    p1_gfx   = ps[OBJ_P1];
    ball_en  = bs;
    p0_new   = pn[OBJ_P0];
    p0_old   = po[OBJ_P0];
    p1_new   = pn[OBJ_P1];
    p1_old   = po[OBJ_P1];
    ball_new = bn;
    ball_old = bo;
    dly_sel  = dly_q;
  end

  // R3 / R7: an address-0 bus write copies player-1 new into old, seen two edges on
  a_r7_copy_p1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(ADR_GFX0)) |=> ##1 (p1_old == $past(p1_new)));
  // R5: a ball write leaves both player old registers alone
  a_r5_ball_only: assert property (@(posedge clk) disable iff (rst)
    (q_vld && q_addr == ADDR_W'(ADR_BALL)) |=> ($stable(p0_old) && $stable(p1_old) && $stable(ball_old)));
endmodule

// File: tb/test_sprite_vdelay.sv
module test_sprite_vdelay;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] p0_gfx, p1_gfx, p0_new, p0_old, p1_new, p1_old;
  logic       ball_en, ball_new, ball_old;
  logic [2:0] dly_sel;

  sprite_vdelay i_sprite_vdelay (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .p0_gfx(p0_gfx), .p1_gfx(p1_gfx), .ball_en(ball_en),
    .p0_new(p0_new), .p0_old(p0_old), .p1_new(p1_new), .p1_old(p1_old),
    .ball_new(ball_new), .ball_old(ball_old), .dly_sel(dly_sel)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference: register state plus one pending write
  int m_new [3];
  int m_old [3];
  int m_dly [3];
  bit pend_v = 0;
  int pend_a = 0;
  int pend_d = 0;

  function automatic int sel(int k);
    return (m_dly[k] != 0) ? m_old[k] : m_new[k];
  endfunction

  task automatic cmp(string req, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, nm, act, exp, cycles);
    end
  endtask

  task automatic check_all();
    cmp(tag, "p0_gfx", int'(p0_gfx), sel(0));
    cmp(tag, "p1_gfx", int'(p1_gfx), sel(1));
    cmp(tag, "ball_en", int'(ball_en), sel(2));
    cmp("R10", "p0_new", int'(p0_new), m_new[0]);
    cmp("R10", "p0_old", int'(p0_old), m_old[0]);
    cmp("R10", "p1_new", int'(p1_new), m_new[1]);
    cmp("R10", "p1_old", int'(p1_old), m_old[1]);
    cmp("R10", "ball_new", int'(ball_new), m_new[2]);
    cmp("R10", "ball_old", int'(ball_old), m_old[2]);
    cmp("R10", "dly_sel", int'(dly_sel), m_dly[0] + 2*m_dly[1] + 4*m_dly[2]);
  endtask

  task automatic model_apply(int a, int d);
    case (a)
      0: begin m_old[1] = m_new[1]; m_new[0] = d; end
      1: begin m_old[0] = m_new[0]; m_old[2] = m_new[2]; m_new[1] = d; end
      2: m_new[2] = (d >> 1) & 1;
      3, 4, 5: m_dly[a-3] = d & 1;
      default: ;
    endcase
  endtask

  // one clock: compare, drive, advance model to the state after next edge
  task automatic cyc(bit r, bit we, int a, int d);
    @(negedge clk);
    check_all();
    rst = r; wr_en = we; wr_addr = 3'(a); wr_data = 8'(d);
    if (r) begin
      for (int k = 0; k < 3; k++) begin m_new[k] = 0; m_old[k] = 0; m_dly[k] = 0; end
      pend_v = 0;
    end else begin
      if (pend_v) model_apply(pend_a, pend_d);
      pend_v = we; pend_a = a; pend_d = d;
    end
  endtask

  task automatic wr(int a, int d);
    cyc(0, 1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int lf;
    for (int k = 0; k < 3; k++) begin m_new[k] = 0; m_old[k] = 0; m_dly[k] = 0; end
    tag = "R1"; cyc(1, 0, 0, 0); cyc(1, 1, 0, 8'hff); cyc(0, 0, 0, 0); idle(2);

    tag = "R2"; wr(0, 8'h3c); idle(2); wr(0, 8'ha5); idle(2);
    tag = "R3"; wr(1, 8'h11); idle(1); wr(0, 8'h42); idle(2);
    tag = "R5"; wr(2, 8'h02); idle(1); wr(2, 8'hfd); idle(1); wr(2, 8'hff); idle(2);
    tag = "R4"; wr(1, 8'h77); idle(2); wr(2, 8'h00); wr(1, 8'h99); idle(2);
    tag = "R6"; wr(3, 8'h01); idle(1); wr(4, 8'hff); idle(1); wr(5, 8'h01); idle(2);
    wr(0, 8'hc3); idle(1); wr(1, 8'h5a); idle(2);
    wr(3, 8'hfe); wr(4, 8'h00); idle(2);
    tag = "R7";
    for (int m = 0; m < 8; m++) begin
      wr(3, m & 1); wr(4, (m >> 1) & 1); wr(5, (m >> 2) & 1);
      wr(0, 8'h10 + m); wr(2, (m & 1) << 1); wr(1, 8'h80 + m); wr(0, 8'h20 + m);
      idle(2);
    end
    tag = "R8";
    for (int i = 0; i < 24; i++) wr(i & 1, (i * 37 + 5) & 8'hff);
    wr(2, 8'h02); wr(1, 8'h01); wr(0, 8'h02); wr(1, 8'h03); idle(2);
    tag = "R9"; wr(6, 8'hff); wr(7, 8'h5a); idle(1); wr(5, 8'hfe); wr(2, 8'hfd); idle(2);
    tag = "R8";
    lf = 32'h1ace;
    for (int i = 0; i < 400; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hb400 : 0);
      if ((lf & 3) != 0) wr((lf >> 2) & 7, (lf >> 5) & 8'hff);
      else idle(1);
    end
    idle(2);
    tag = "R1"; wr(0, 8'hee); cyc(1, 1, 1, 8'hff); idle(3);
    @(negedge clk); check_all();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule